// File: doc/BRIEF.md
# Programmable Baud Clock Divider with Delayed Start

This block divides a chosen counting source down to a square-wave baud clock for one serial channel. Three sources are available, and all of them are counting strobes inside the single system clock domain. The first is the processor clock, so every system clock counts. The second is a strobe from an external clock pin. The third is a strobe from a crystal oscillator. Software writes a 16-bit time constant, a source mode and an enable bit through three independent write strobes.

The output toggles once per half period. Each half period spans TC+2 counts: one count loads the time constant, TC counts decrement it to zero, and one count at zero toggles the output. Starting is deliberately slow, because two arming counts must pass before the first load, which lets the start command line up with the source. Stopping is abrupt: once the enable register reads 0, no further count has any effect and the output holds its level.

Control is a four-state machine. IDLE is the stopped state and moves to ARM when enable is set. ARM waits two counts and then moves to RELOAD. RELOAD loads the time constant on a count and moves to COUNT. COUNT decrements on each count; on a count at zero it toggles the output and returns to RELOAD. Clearing enable sends every state back to IDLE.

Top module: `baud_gen_sync`

## Requirements
- R1: After reset, baud_out is 0, the enable is off, the time constant is 0 and the source mode selects the external pin strobe. Setting only the enable after reset therefore counts pin_tick strobes, and the first toggle comes on the 4th strobe.
- R2: With mode_src_pclk=1, every system clock is a count. The output period is 2×(TC+2) clocks.
- R3: With mode_src_pclk=0 and mode_xtal=0, only clocks with pin_tick=1 are counts, and xtal_tick has no effect on the output.
- R4: With mode_src_pclk=0 and mode_xtal=1, only clocks with xtal_tick=1 are counts, and pin_tick has no effect on the output.
- R5: After the enable is written to 1, one clock is spent leaving IDLE. The first toggle then comes on the (TC+4)th count (two arming, one load, TC decrement, one terminal). With the processor clock as source, that toggle is seen TC+5 clocks after the write edge.
- R6: Once the enable register reads 0, counting stops at the next edge and baud_out holds its level for as long as the enable stays 0.
- R7: A time-constant write during a half period leaves that half period unchanged. The new value applies from the next reload.
- R8: The output changes only on a count at which the counter is zero, so TC=0 gives a half period of 2 counts.
- R9: Re-enabling after a stop restarts the full arming sequence and a fresh load, and does not resume the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (processor) clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tc_we | input | 1 | Write strobe for the time constant |
| tc_wdata | input | CNT_W | Time constant value |
| mode_we | input | 1 | Write strobe for the source mode |
| mode_src_pclk | input | 1 | 1: count every clock; 0: count an external strobe |
| mode_xtal | input | 1 | When the external strobe is used, 1 selects xtal_tick and 0 selects pin_tick |
| en_we | input | 1 | Write strobe for the enable |
| en_wdata | input | 1 | Enable value |
| pin_tick | input | 1 | Count strobe from the external clock pin, synchronous to clk |
| xtal_tick | input | 1 | Count strobe from the crystal oscillator, synchronous to clk |
| baud_out | output | 1 | Divided baud clock |

## Verification
The hardest situation to reach is a time-constant write that lands inside a half period, after the reload has already captured the old value but before the terminal count. The stimulus locates a toggle at the ports, waits exactly one clock so that the reload has happened, and then writes the new constant. The bench then requires one more half period at the old length followed by one at the new length. The stop-and-restart case is handled the same way: the enable is cleared shortly after a toggle, the output is watched for a long quiet interval, and the bench then expects the full arming delay again rather than the remainder of the old count.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARM    = 2'd1,
        S_RELOAD = 2'd2,
        S_COUNT  = 2'd3
    } brg_state_t;
endpackage

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tc_we,
    input  logic [CNT_W-1:0] tc_wdata,
    input  logic             mode_we,
    input  logic             mode_src_pclk,
    input  logic             mode_xtal,
    input  logic             en_we,
    input  logic             en_wdata,
    output logic [CNT_W-1:0] tc_q,
    output logic             src_pclk_q,
    output logic             xtal_q,
    output logic             en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q       <= '0;
            src_pclk_q <= 1'b0;
            xtal_q     <= 1'b0;
            en_q       <= 1'b0;
        end else begin
            if (tc_we)   tc_q <= tc_wdata;
            if (mode_we) begin
                src_pclk_q <= mode_src_pclk;
                xtal_q     <= mode_xtal;
            end
            if (en_we)   en_q <= en_wdata;
        end
    end
endmodule

// File: rtl/brg_src_sel.sv
module brg_src_sel (
    input  logic src_pclk,
    input  logic xtal_sel,
    input  logic pin_tick,
    input  logic xtal_tick,
    output logic ce
);
    logic ext_tick;

    always_comb begin
        ext_tick = xtal_sel ? xtal_tick : pin_tick;
        ce       = src_pclk ? 1'b1 : ext_tick;
    end
endmodule

// File: rtl/brg_down_cnt.sv
module brg_down_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] tc,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= tc;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R8: the controller never asks for a decrement past zero
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);

    // R7: a reload captures the time constant present at that edge
    a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(tc));
endmodule

// File: rtl/brg_fsm.sv
module brg_fsm
    import brg_pkg::*;
#(
    parameter int ARM_COUNTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ce,
    input  logic zero,
    output logic load,
    output logic dec,
    output logic baud_out
);
    localparam int ARM_W = (ARM_COUNTS > 1) ? $clog2(ARM_COUNTS) : 1;

    brg_state_t       state, state_nx;
    logic [ARM_W-1:0] arm_cnt;
    logic             arm_last;
    logic             tgl;

    assign arm_last = (arm_cnt == ARM_W'(ARM_COUNTS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    arm_cnt <= '0;
        else if (state_nx != S_ARM)    arm_cnt <= '0;
        else if (state == S_ARM && ce) arm_cnt <= arm_cnt + 1'b1;
    end

    // next state and strobes
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        dec      = 1'b0;
        tgl      = 1'b0;
        unique case (state)
            S_IDLE:   if (en) state_nx = S_ARM;
            S_ARM:    if (ce && arm_last) state_nx = S_RELOAD;
            S_RELOAD: if (ce) begin
                load     = 1'b1;
                state_nx = S_COUNT;
            end
            S_COUNT:  if (ce) begin
                if (zero) begin
                    tgl      = 1'b1;
                    state_nx = S_RELOAD;
                end else begin
                    dec = 1'b1;
                end
            end
        endcase
        if (!en) begin
            state_nx = S_IDLE;
            load     = 1'b0;
            dec      = 1'b0;
            tgl      = 1'b0;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   baud_out <= 1'b0;
        else if (tgl) baud_out <= ~baud_out;
    end

    // R5: a set enable always leaves IDLE through ARM
    a_r5_arm_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && en) |=> state == S_ARM);

    // R6: a cleared enable parks the machine at the next edge
    a_r6_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == S_IDLE);

    // R6: the output never moves while the machine is idle
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(baud_out));
endmodule

// File: rtl/baud_gen_sync.sv
module baud_gen_sync #(
    parameter int CNT_W      = 16,
    parameter int ARM_COUNTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tc_we,
    input  logic [CNT_W-1:0] tc_wdata,
    input  logic             mode_we,
    input  logic             mode_src_pclk,
    input  logic             mode_xtal,
    input  logic             en_we,
    input  logic             en_wdata,
    input  logic             pin_tick,
    input  logic             xtal_tick,
    output logic             baud_out
);
    logic [CNT_W-1:0] tc_q;
    logic [CNT_W-1:0] cnt;
    logic             src_pclk_q, xtal_q, en_q;
    logic             ce, zero, load, dec;

    brg_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .tc_we        (tc_we),
        .tc_wdata     (tc_wdata),
        .mode_we      (mode_we),
        .mode_src_pclk(mode_src_pclk),
        .mode_xtal    (mode_xtal),
        .en_we        (en_we),
        .en_wdata     (en_wdata),
        .tc_q         (tc_q),
        .src_pclk_q   (src_pclk_q),
        .xtal_q       (xtal_q),
        .en_q         (en_q)
    );

    brg_src_sel u_src (
        .src_pclk (src_pclk_q),
        .xtal_sel (xtal_q),
        .pin_tick (pin_tick),
        .xtal_tick(xtal_tick),
        .ce       (ce)
    );

    brg_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .dec  (dec),
        .tc   (tc_q),
        .cnt  (cnt),
        .zero (zero)
    );

    brg_fsm #(.ARM_COUNTS(ARM_COUNTS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .ce      (ce),
        .zero    (zero),
        .load    (load),
        .dec     (dec),
        .baud_out(baud_out)
    );

    // R2/R3/R4: no count from the selected source means a frozen counter
    a_r2_hold_without_count: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(cnt));

    // R6: with the enable register clear the output holds its level
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(baud_out));

    // R8: an output change follows a count taken at zero
    a_r8_toggle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(baud_out) |-> $past(ce && zero));
endmodule

// File: tb/baud_gen_sync_bench.sv
`timescale 1ns/1ps
module baud_gen_sync_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tc_we = 1'b0;
    logic [CNT_W-1:0] tc_wdata = '0;
    logic             mode_we = 1'b0;
    logic             mode_src_pclk = 1'b0;
    logic             mode_xtal = 1'b0;
    logic             en_we = 1'b0;
    logic             en_wdata = 1'b0;
    logic             pin_tick = 1'b0;
    logic             xtal_tick = 1'b0;
    logic             baud_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    baud_gen_sync #(.CNT_W(CNT_W), .ARM_COUNTS(2)) u_baud_gen_sync (
        .clk(clk), .rst_n(rst_n),
        .tc_we(tc_we), .tc_wdata(tc_wdata),
        .mode_we(mode_we), .mode_src_pclk(mode_src_pclk), .mode_xtal(mode_xtal),
        .en_we(en_we), .en_wdata(en_wdata),
        .pin_tick(pin_tick), .xtal_tick(xtal_tick),
        .baud_out(baud_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_tc(input int v);
        tc_wdata = CNT_W'(v); tc_we = 1'b1;
        @(negedge clk); tc_we = 1'b0;
    endtask

    task automatic wr_mode(input bit pclk, input bit xtal);
        mode_src_pclk = pclk; mode_xtal = xtal; mode_we = 1'b1;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_en(input bit v);
        en_wdata = v; en_we = 1'b1;
        @(negedge clk); en_we = 1'b0;
    endtask

    task automatic wait_edge(output int n);
        logic prev;
        prev = baud_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (baud_out == prev && n < 2000);
    endtask

    task automatic pulse(input bit use_xtal);
        if (use_xtal) xtal_tick = 1'b1; else pin_tick = 1'b1;
        @(negedge clk);
        xtal_tick = 1'b0; pin_tick = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string req, input logic lvl);
        int moved = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (baud_out !== lvl) moved++;
        end
        chk(moved == 0, req, moved, 0);
    endtask

    // R1: reset state, and the reset source is the pin strobe
    task automatic t_reset();
        int n;
        do_reset();
        chk(baud_out === 1'b0, "R1 reset level", baud_out, 0);
        wr_mode(1'b1, 1'b0); wr_tc(2); wr_en(1'b1);
        wait_edge(n);
        chk(baud_out === 1'b1, "R1 running before reset", baud_out, 1);
        do_reset();
        chk(baud_out === 1'b0, "R1 level after mid-run reset", baud_out, 0);
        quiet(30, "R1 enable cleared by reset", 1'b0);
        wr_en(1'b1);
        @(negedge clk);
        quiet(30, "R1 source not processor clock", 1'b0);
        for (int k = 1; k <= 4; k++) begin
            pulse(1'b0);
            chk(baud_out === (k >= 4), "R1 pin source with tc 0", baud_out, (k >= 4));
        end
    endtask

    // R2, R5: processor clock period and enable delay
    task automatic t_pclk(input int tc);
        int n;
        do_reset();
        wr_mode(1'b1, 1'b0); wr_tc(tc); wr_en(1'b1);
        wait_edge(n);
        chk(n == tc + 5, "R5 first toggle delay", n, tc + 5);
        for (int i = 0; i < 3; i++) begin
            wait_edge(n);
            chk(n == tc + 2, "R2 half period", n, tc + 2);
        end
    endtask

    // R8: smallest time constant
    task automatic t_tc_zero();
        int n;
        do_reset();
        wr_mode(1'b1, 1'b0); wr_tc(0); wr_en(1'b1);
        wait_edge(n);
        chk(n == 5, "R8 first toggle tc 0", n, 5);
        wait_edge(n);
        chk(n == 2, "R8 half period tc 0", n, 2);
        wait_edge(n);
        chk(n == 2, "R8 half period tc 0", n, 2);
    endtask

    // R3 (pin) or R4 (crystal), with the other strobe interleaved
    task automatic t_ext(input bit use_xtal, input int tc, input string req);
        logic exp;
        int next_t;
        do_reset();
        wr_mode(1'b0, use_xtal); wr_tc(tc); wr_en(1'b1);
        @(negedge clk);
        exp = 1'b0;
        next_t = tc + 4;
        for (int k = 1; k <= 3 * (tc + 2) + 2; k++) begin
            pulse(use_xtal);
            if (k == next_t) begin
                exp = ~exp;
                next_t += tc + 2;
            end
            chk(baud_out === exp, req, baud_out, exp);
            pulse(!use_xtal);
            chk(baud_out === exp, {req, " other strobe ignored"}, baud_out, exp);
            @(negedge clk);
            chk(baud_out === exp, {req, " idle clock ignored"}, baud_out, exp);
        end
    endtask

    // R6, R9: stop, hold, restart
    task automatic t_stop();
        int n;
        do_reset();
        wr_mode(1'b1, 1'b0); wr_tc(3); wr_en(1'b1);
        wait_edge(n);
        chk(n == 8, "R6 setup toggle", n, 8);
        repeat (2) @(negedge clk);
        wr_en(1'b0);
        quiet(40, "R6 output held after stop", 1'b1);
        wr_en(1'b1);
        wait_edge(n);
        chk(n == 8, "R9 restart uses full arm and load", n, 8);
        chk(baud_out === 1'b0, "R9 restart toggles held level", baud_out, 0);
    endtask

    // R7: time-constant write lands inside a half period
    task automatic t_tc_change();
        int n;
        do_reset();
        wr_mode(1'b1, 1'b0); wr_tc(5); wr_en(1'b1);
        wait_edge(n);
        chk(n == 10, "R7 setup toggle", n, 10);
        @(negedge clk);
        wr_tc(2);
        wait_edge(n);
        chk(n == 5, "R7 current half period keeps old tc", n, 5);
        wait_edge(n);
        chk(n == 4, "R7 next half period uses new tc", n, 4);
        wait_edge(n);
        chk(n == 4, "R7 new tc persists", n, 4);
    endtask

    initial begin
        t_reset();
        t_pclk(5);
        t_pclk(1);
        t_tc_zero();
        t_ext(1'b0, 3, "R3 pin source");
        t_ext(1'b1, 2, "R4 crystal source");
        t_stop();
        t_tc_change();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule